// File: doc/BRIEF.md
# Prescaled Instruction-Cycle Timer

This block is an 8-bit timer/counter for a small processor core. A hidden prescaler sits in front of the timer and counts instruction-cycle enable pulses. Each time the prescaler completes its divide count, the timer advances by one. A 4-bit ratio code selects a divide ratio between 1:2 and 1:256.

Software can load the timer at any time through a write strobe, and it always sees the live count on the read-back port. Whenever the phase of the prescaler could be stale, the prescaler restarts from zero. This happens on any timer load, on any ratio write, and on each of the three reset sources: the asynchronous power-on reset, a synchronous external reset and a synchronous watchdog time-out reset. A new preload or ratio therefore always counts a full period. When the timer rolls over from 0xFF to 0x00, a one-cycle overflow pulse is raised.

The prescaler is a two-state machine:
- `PH_ALIGNED`: the divide count is zero.
- `PH_ACCUM`: a partial count is held.

Its transitions are:
- `start`: PH_ALIGNED to PH_ACCUM, on an enabled cycle without a clear.
- `complete`: PH_ACCUM to PH_ALIGNED, on the enabled cycle that reaches the terminal count, which raises the timer tick.
- `restart`: any state to PH_ALIGNED, on a clear.
- `hold`: otherwise the state is kept.

Top module: `cyc_timer`

## Requirements
- R1: After power-on reset (rst_n low), tmr_q is 0x00, ovf_o is 0, and the ratio code is 0.
- R2: Ratio codes 0 to 7 on ratio_wdata[3:0] select a divide ratio of 2^(code+1). Codes 8 to 15 select 1:256.
- R3: The timer advances by exactly one on the enabled cycle (cyc_en high) that completes the divide count. Cycles with cyc_en low neither advance the timer nor the prescaler.
- R4: With tmr_wr high, tmr_q takes tmr_wdata on the next cycle and the prescaler restarts. The next increment then comes after a full ratio of enabled cycles.
- R5: A ratio write restarts the prescaler with the new ratio. In the cycle of the write, the timer does not advance.
- R6: When a timer write and a would-be increment fall in the same cycle, the written value is kept and no increment occurs.
- R7: An increment from 0xFF wraps the timer to 0x00. ovf_o is high for exactly that one following cycle, while tmr_q reads 0x00.
- R8: ext_rst or wdt_rst clears the timer, the overflow pulse, the prescaler and the ratio code on the next cycle. Either reset overrides any write made in the same cycle.
- R9: A timer write never raises ovf_o, even when it replaces 0xFF with 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| ext_rst | input | 1 | Synchronous external reset request |
| wdt_rst | input | 1 | Synchronous watchdog time-out reset request |
| cyc_en | input | 1 | Instruction-cycle enable pulse |
| tmr_wr | input | 1 | Timer write strobe |
| tmr_wdata | input | 8 | Timer write data |
| ratio_wr | input | 1 | Ratio field write strobe |
| ratio_wdata | input | 4 | Ratio code |
| tmr_q | output | 8 | Timer read-back value |
| ovf_o | output | 1 | One-cycle overflow pulse |

## Verification
Some rules are checked by assertions on every cycle:
- the timer moves by at most one step, and only when enabled;
- writes load exactly the written value;
- either synchronous reset clears the timer;
- ovf_o is a single-cycle pulse seen only with a zero count, and never follows a write.

Other behaviour needs the bench's scenarios and its cycle-accurate reference model:
- the exact divide ratio for each of the sixteen codes;
- the full period that follows a preload or a ratio change made mid-phase;
- the dropped increment when a write meets a terminal count.

// File: rtl/cyc_timer_pkg.sv
package cyc_timer_pkg;

    // Phase of the prescaler: clean (zero count) or holding a partial count
    typedef enum logic [0:0] {
        PH_ALIGNED = 1'b0,
        PH_ACCUM   = 1'b1
    } phase_e;

endpackage

// File: rtl/cyc_timer_ratio.sv
module cyc_timer_ratio #(
    parameter int SEL_W   = 4,
    parameter int MAX_LOG = 8,
    localparam int PRE_W  = MAX_LOG
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_clr,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wdata,
    output logic [PRE_W-1:0] term
);

    localparam logic [SEL_W-1:0] TOP_CODE = SEL_W'(MAX_LOG - 1);

    logic [SEL_W-1:0] code_q;
    logic [SEL_W-1:0] eff_code;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= '0;
        end else if (sync_clr) begin
            code_q <= '0;
        end else if (wr_en) begin
            code_q <= wdata;
        end
    end

    // Codes past the largest ratio saturate at it
    always_comb begin
        eff_code = (code_q > TOP_CODE) ? TOP_CODE : code_q;
    end

    // Terminal count 2^(code+1)-1: bits 0..code are set
    for (genvar gi = 0; gi < PRE_W; gi++) begin : g_term
        assign term[gi] = (int'(eff_code) >= gi);
    end

endmodule

// File: rtl/cyc_timer_presc.sv
module cyc_timer_presc
    import cyc_timer_pkg::*;
#(
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             cyc_en,
    input  logic [PRE_W-1:0] term,
    output logic             tick
);

    phase_e           state_q, state_d;
    logic [PRE_W-1:0] cnt_q, cnt_d;
    logic             at_term;

    assign at_term = (cnt_q == term);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PH_ALIGNED;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next state and count
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (clr) begin
            state_d = PH_ALIGNED;                 // restart
            cnt_d   = '0;
        end else if (cyc_en) begin
            unique case (state_q)
                PH_ALIGNED: begin
                    if (at_term) begin
                        cnt_d = '0;
                    end else begin
                        state_d = PH_ACCUM;       // start
                        cnt_d   = cnt_q + 1'b1;
                    end
                end
                PH_ACCUM: begin
                    if (at_term) begin
                        state_d = PH_ALIGNED;     // complete
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;     // hold phase
                    end
                end
                default: begin
                    state_d = PH_ALIGNED;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        tick = 1'b0;
        if (!clr && cyc_en) begin
            unique case (state_q)
                PH_ALIGNED: tick = at_term;
                PH_ACCUM:   tick = at_term;
                default:    tick = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/cyc_timer_count.sv
module cyc_timer_count #(
    parameter int TMR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_clr,
    input  logic             wr_en,
    input  logic [TMR_W-1:0] wdata,
    input  logic             tick,
    output logic [TMR_W-1:0] q,
    output logic             ovf
);

    localparam logic [TMR_W-1:0] ALL_ONES = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q   <= '0;
            ovf <= 1'b0;
        end else if (sync_clr) begin
            q   <= '0;
            ovf <= 1'b0;
        end else begin
            ovf <= tick && !wr_en && (q == ALL_ONES);
            if (wr_en) begin
                q <= wdata;
            end else if (tick) begin
                q <= q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/cyc_timer.sv
module cyc_timer #(
    parameter int TMR_W   = 8,
    parameter int SEL_W   = 4,
    parameter int MAX_LOG = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_rst,
    input  logic             wdt_rst,
    input  logic             cyc_en,
    input  logic             tmr_wr,
    input  logic [TMR_W-1:0] tmr_wdata,
    input  logic             ratio_wr,
    input  logic [SEL_W-1:0] ratio_wdata,
    output logic [TMR_W-1:0] tmr_q,
    output logic             ovf_o
);

    localparam int PRE_W = MAX_LOG;

    logic             sync_clr;
    logic             presc_clr;
    logic [PRE_W-1:0] term;
    logic             tick;

    assign sync_clr  = ext_rst | wdt_rst;
    assign presc_clr = sync_clr | tmr_wr | ratio_wr;

    cyc_timer_ratio #(.SEL_W(SEL_W), .MAX_LOG(MAX_LOG)) i_ratio (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_clr (sync_clr),
        .wr_en    (ratio_wr),
        .wdata    (ratio_wdata),
        .term     (term)
    );

    cyc_timer_presc #(.PRE_W(PRE_W)) i_presc (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (presc_clr),
        .cyc_en (cyc_en),
        .term   (term),
        .tick   (tick)
    );

    cyc_timer_count #(.TMR_W(TMR_W)) i_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_clr (sync_clr),
        .wr_en    (tmr_wr),
        .wdata    (tmr_wdata),
        .tick     (tick),
        .q        (tmr_q),
        .ovf      (ovf_o)
    );

endmodule

// File: rtl/cyc_timer_chk.sv
module cyc_timer_chk #(
    parameter int TMR_W = 8,
    parameter int SEL_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ext_rst,
    input logic             wdt_rst,
    input logic             cyc_en,
    input logic             tmr_wr,
    input logic [TMR_W-1:0] tmr_wdata,
    input logic             ratio_wr,
    input logic [SEL_W-1:0] ratio_wdata,
    input logic [TMR_W-1:0] tmr_q,
    input logic             ovf_o
);

    logic any_rst;
    assign any_rst = ext_rst | wdt_rst;

    assert_sync_reset_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        any_rst |=> (tmr_q == '0 && !ovf_o));

    assert_write_loads_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_wr && !any_rst) |=> (tmr_q == $past(tmr_wdata)));

    assert_write_beats_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_wr && cyc_en && !any_rst) |=> (tmr_q == $past(tmr_wdata)));

    assert_hold_without_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cyc_en && !tmr_wr && !any_rst) |=> $stable(tmr_q));

    assert_single_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!tmr_wr && !any_rst) |=> (tmr_q == $past(tmr_q) || tmr_q == $past(tmr_q) + TMR_W'(1)));

    assert_ratio_write_no_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ratio_wr && !tmr_wr && !any_rst) |=> $stable(tmr_q));

    assert_ovf_at_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |-> (tmr_q == '0));

    assert_ovf_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |=> !ovf_o);

    assert_write_no_ovf_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_wr |=> !ovf_o);

    // R1: reset state
    always_comb begin
        if (!rst_n) begin
            assert_reset_state_R1: assert (tmr_q == '0 && !ovf_o);
        end
    end

endmodule

bind cyc_timer cyc_timer_chk #(.TMR_W(TMR_W), .SEL_W(SEL_W)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ext_rst     (ext_rst),
    .wdt_rst     (wdt_rst),
    .cyc_en      (cyc_en),
    .tmr_wr      (tmr_wr),
    .tmr_wdata   (tmr_wdata),
    .ratio_wr    (ratio_wr),
    .ratio_wdata (ratio_wdata),
    .tmr_q       (tmr_q),
    .ovf_o       (ovf_o)
);

// File: tb/test_cyc_timer.sv
`timescale 1ns/1ps
module test_cyc_timer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_rst = 1'b0, wdt_rst = 1'b0, cyc_en = 1'b0;
    logic       tmr_wr = 1'b0, ratio_wr = 1'b0;
    logic [7:0] tmr_wdata = '0;
    logic [3:0] ratio_wdata = '0;
    logic [7:0] tmr_q;
    logic       ovf_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // Reference state
    int m_tmr = 0, m_cnt = 0, m_code = 0;
    bit m_ovf = 0;

    always #10 clk = ~clk;

    cyc_timer i_cyc_timer (
        .clk(clk), .rst_n(rst_n), .ext_rst(ext_rst), .wdt_rst(wdt_rst),
        .cyc_en(cyc_en), .tmr_wr(tmr_wr), .tmr_wdata(tmr_wdata),
        .ratio_wr(ratio_wr), .ratio_wdata(ratio_wdata),
        .tmr_q(tmr_q), .ovf_o(ovf_o)
    );

    function automatic int ratio_of(input int code);
        return 2 << ((code > 7) ? 7 : code);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Reference update for one clock edge, using the inputs now applied
    task automatic model_step();
        if (ext_rst || wdt_rst) begin
            m_tmr = 0; m_cnt = 0; m_code = 0; m_ovf = 0;
        end else begin
            bit tk = 0;
            m_ovf = 0;
            if (tmr_wr || ratio_wr) begin
                m_cnt = 0;
            end else if (cyc_en) begin
                if (m_cnt == ratio_of(m_code) - 1) begin
                    m_cnt = 0; tk = 1;
                end else begin
                    m_cnt++;
                end
            end
            if (ratio_wr) m_code = ratio_wdata;
            if (tmr_wr) begin
                m_tmr = tmr_wdata;
            end else if (tk) begin
                m_ovf = (m_tmr == 255);
                m_tmr = (m_tmr + 1) % 256;
            end
        end
    endtask

    task automatic cyc(input string req, input bit en, input bit twr, input int td,
                       input bit rwr, input int rd, input bit er, input bit wr_);
        @(negedge clk);
        cyc_en = en; tmr_wr = twr; tmr_wdata = td[7:0];
        ratio_wr = rwr; ratio_wdata = rd[3:0]; ext_rst = er; wdt_rst = wr_;
        @(posedge clk);
        model_step();
        #1;
        check(req, tmr_q, m_tmr);
        check(req, ovf_o, m_ovf);
    endtask

    task automatic run_en(input string req, input int n);
        for (int i = 0; i < n; i++) cyc(req, 1, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : stim
        int unsigned seed;
        seed = $urandom(32'd20117);
        repeat (3) @(posedge clk);
        #1;
        check("R1", tmr_q, 0);
        check("R1", ovf_o, 0);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset ratio is 1:2 -> tick after two enabled cycles
        run_en("R1", 1);
        check("R1", tmr_q, 0);
        run_en("R1", 1);
        check("R1", tmr_q, 1);

        // R2: sweep every code, preload and ratio in the same cycle
        for (int c = 0; c < 16; c++) begin
            cyc("R2", 0, 1, 0, 1, c, 0, 0);
            run_en("R2", ratio_of(c) - 1);
            check("R2", tmr_q, 0);
            run_en("R2", 1);
            check("R2", tmr_q, 1);
        end

        // R3: disabled cycles do not advance
        cyc("R3", 0, 0, 0, 1, 1, 0, 0);      // ratio 1:4
        run_en("R3", 2);
        for (int i = 0; i < 20; i++) cyc("R3", 0, 0, 0, 0, 0, 0, 0);
        check("R3", tmr_q, 1);
        run_en("R3", 2);
        check("R3", tmr_q, 2);

        // R4: preload mid-phase restarts the prescaler
        run_en("R4", 3);
        cyc("R4", 0, 1, 8'h40, 0, 0, 0, 0);
        check("R4", tmr_q, 8'h40);
        run_en("R4", 3);
        check("R4", tmr_q, 8'h40);
        run_en("R4", 1);
        check("R4", tmr_q, 8'h41);

        // R5: ratio change mid-phase, no tick in the write cycle
        run_en("R5", 3);
        cyc("R5", 1, 0, 0, 1, 0, 0, 0);      // would complete 1:4, now 1:2
        check("R5", tmr_q, 8'h41);
        run_en("R5", 2);
        check("R5", tmr_q, 8'h42);

        // R6: write coincides with a terminal count
        run_en("R6", 1);
        cyc("R6", 1, 1, 8'h55, 0, 0, 0, 0);
        check("R6", tmr_q, 8'h55);
        run_en("R6", 2);
        check("R6", tmr_q, 8'h56);

        // R7: wrap and single overflow pulse
        cyc("R7", 0, 1, 8'hFF, 0, 0, 0, 0);
        run_en("R7", 2);
        check("R7", tmr_q, 0);
        check("R7", ovf_o, 1);
        run_en("R7", 1);
        check("R7", ovf_o, 0);

        // R9: write 00 over FF raises no overflow
        cyc("R9", 0, 1, 8'hFF, 0, 0, 0, 0);
        cyc("R9", 1, 1, 8'h00, 0, 0, 0, 0);
        check("R9", ovf_o, 0);

        // R8: both sync resets beat writes and reset the ratio
        cyc("R8", 0, 0, 0, 1, 5, 0, 0);
        cyc("R8", 1, 1, 8'h77, 1, 3, 1, 0);
        check("R8", tmr_q, 0);
        run_en("R8", 2);
        check("R8", tmr_q, 1);
        cyc("R8", 0, 1, 8'h90, 1, 6, 0, 1);
        check("R8", tmr_q, 0);
        run_en("R8", 2);
        check("R8", tmr_q, 1);

        // Constrained random mix against the reference (R3 and others)
        for (int i = 0; i < 6000; i++) begin
            bit en, twr, rwr, er, wr_;
            int td, rd;
            en  = ($urandom % 4) != 0;
            twr = ($urandom % 40) == 0;
            rwr = ($urandom % 60) == 0;
            er  = ($urandom % 500) == 0;
            wr_ = ($urandom % 500) == 0;
            td  = (($urandom % 2) != 0) ? 8'hF0 + ($urandom % 16) : $urandom % 256;
            rd  = $urandom % 4;
            cyc("R3", en, twr, td, rwr, rd, er, wr_);
        end
        cyc("R3", 0, 0, 0, 0, 0, 0, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule